// File: doc/BRIEF.md
# Programmable-Order CIC Decimator

This block is a cascaded integrator-comb decimator for one real sample stream. A signed input sample is taken on every cycle in which its valid strobe is high. A chain of integrators runs at the input rate. Once every R accepted samples, where R is the decimation factor, the chain is sampled into an equally long chain of differentiators. The result then passes through an arithmetic right shifter, which removes the bit growth of the filter, and leaves with a one-cycle output-valid pulse.

The number of stages (1 to 5), the decimation factor and the shift amount are set at run time through a load strobe. The longest legal decimation factor gets shorter as the order rises, because the accumulators have a fixed width. The block checks every load. A load that passes becomes the new setting and clears the filter state. A load that fails raises an error flag and changes nothing. Stages above the chosen order are left out of the path, so a low order behaves exactly like a shorter cascade.

Top module: `cic_decim`

## Requirements
- R1: After reset, out_valid_o and cfg_err_o are 0 and the active setting is order 5, decimation 4, shift 10.
- R2: With order N (1..5) the output equals the response of N integrators followed by N differentiators; stages above N have no effect.
- R3: Integrators wrap in two's complement at ACC_W = IN_W + 5*16 bits. out_data_o is bits [shift+OUT_W-1:shift] of the signed differentiator result, taken after an arithmetic right shift.
- R4: out_valid_o is high for exactly one cycle per R accepted samples. A cycle with in_valid_i low is not counted and has no effect on the output.
- R5: A decimation factor below 4 is rejected for every order.
- R6: The largest legal decimation factor is 512 for order 5, 2048 for order 4, 32768 for order 3 and 65536 for orders 1 and 2. Larger factors are rejected.
- R7: An order of 0, or above 5, is rejected.
- R8: A shift above ACC_W-OUT_W (80 with the default parameters) is rejected.
- R9: A rejected load sets cfg_err_o and keeps the active setting, the filter state and the sample count. An accepted load clears cfg_err_o, the filter state and the count. An input sample presented in the same cycle as an accepted load is dropped.
- R10: out_valid_o is high in the second cycle after the clock edge that accepts the R-th sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | IN_W | Signed input sample |
| cfg_load_i | input | 1 | Apply the configuration inputs |
| cfg_order_i | input | 3 | Filter order, 1..5 |
| cfg_dec_i | input | 17 | Decimation factor |
| cfg_shift_i | input | 7 | Output right shift |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | OUT_W | Scaled decimated sample |
| cfg_err_o | output | 1 | The last load was rejected |

## Verification
A wrong integrator or differentiator value, or a stage left in the path when it should be bypassed, shows as a wrong out_data_o at the very next output strobe. Because the state is recursive, the error then persists at every later strobe. A decimation counter that has slipped moves or adds strobes, and the scoreboard sees this as a value mismatch, or as a queue left non-empty at the end of a phase. A wrong range decision shows on cfg_err_o in the cycle after the load. It also shows at the next strobe, because the output then follows the wrong setting.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int MAX_ORDER = 5;
  localparam int ORD_W     = 3;
  localparam int DEC_W     = 17;
  localparam int SH_W      = 7;
  localparam int MIN_DEC   = 4;

  typedef struct packed {
    logic [ORD_W-1:0] order;
    logic [DEC_W-1:0] dec;
    logic [SH_W-1:0]  shift;
  } cic_cfg_t;

  // Largest legal decimation for a given order; 0 marks an illegal order.
  function automatic logic [DEC_W-1:0] max_dec(input logic [ORD_W-1:0] ord);
    case (ord)
      3'd1, 3'd2: max_dec = DEC_W'(65536);
      3'd3:       max_dec = DEC_W'(32768);
      3'd4:       max_dec = DEC_W'(2048);
      3'd5:       max_dec = DEC_W'(512);
      default:    max_dec = '0;
    endcase
  endfunction
endpackage

// File: rtl/cic_cfg_reg.sv
module cic_cfg_reg
  import cic_pkg::*;
#(
  parameter int ACC_W = 96,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ORD_W-1:0] order_i,
  input  logic [DEC_W-1:0] dec_i,
  input  logic [SH_W-1:0]  shift_i,
  output cic_cfg_t         cfg_o,
  output logic             apply_o,
  output logic             err_o
);
  localparam logic [SH_W-1:0] SH_LIM  = SH_W'(ACC_W - OUT_W);
  localparam logic [SH_W-1:0] DEF_SH  = SH_W'(2 * MAX_ORDER);

  cic_cfg_t cfg_q;
  logic     ok, err_q;

  always_comb begin
    ok = (order_i >= ORD_W'(1)) && (order_i <= ORD_W'(MAX_ORDER))
      && (dec_i >= DEC_W'(MIN_DEC)) && (dec_i <= max_dec(order_i))
      && (shift_i <= SH_LIM);
  end

  assign apply_o = load_i && ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.order <= ORD_W'(MAX_ORDER);
      cfg_q.dec   <= DEC_W'(MIN_DEC);
      cfg_q.shift <= DEF_SH;
      err_q       <= 1'b0;
    end else if (load_i) begin
      err_q <= !ok;
      if (ok) begin
        cfg_q.order <= order_i;
        cfg_q.dec   <= dec_i;
        cfg_q.shift <= shift_i;
      end
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  p_order_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.order >= ORD_W'(1) && cfg_q.order <= ORD_W'(MAX_ORDER));
  p_dec_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.dec <= max_dec(cfg_q.order));
  p_dec_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.dec >= DEC_W'(MIN_DEC));
  p_shift_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.shift <= SH_LIM);
  p_reject_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !apply_o |=> err_q && cfg_q == $past(cfg_q));
  p_accept_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_o |=> !err_q);
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain
  import cic_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 96
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [IN_W-1:0]         data_i,
  input  logic [ORD_W-1:0]        order_i,
  output logic signed [ACC_W-1:0] tap_o
);
  logic signed [ACC_W-1:0] acc_q [MAX_ORDER];
  logic signed [ACC_W-1:0] acc_d [MAX_ORDER];

  for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign acc_d[k] = acc_q[k] + ACC_W'($signed(data_i));
    end else begin : g_next
      assign acc_d[k] = acc_q[k] + acc_d[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      acc_q[k] <= '0;
      else if (clr_i)   acc_q[k] <= '0;
      else if (en_i)    acc_q[k] <= acc_d[k];
    end
  end

  // Tap at the last active stage; higher stages are outside the path.
  always_comb begin
    tap_o = acc_q[0];
    for (int k = 1; k < MAX_ORDER; k++)
      if (order_i == ORD_W'(k + 1)) tap_o = acc_q[k];
  end
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain
  import cic_pkg::*;
#(
  parameter int ACC_W = 96
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [ORD_W-1:0]        order_i,
  input  logic signed [ACC_W-1:0] data_i,
  output logic signed [ACC_W-1:0] res_o
);
  logic signed [ACC_W-1:0] dly_q [MAX_ORDER];
  logic signed [ACC_W-1:0] stg_in [MAX_ORDER];
  logic signed [ACC_W-1:0] stg_out[MAX_ORDER];

  for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stg_in[k] = data_i;
    end else begin : g_next
      assign stg_in[k] = stg_out[k-1];
    end

    assign stg_out[k] = (order_i > ORD_W'(k)) ? stg_in[k] - dly_q[k] : stg_in[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q[k] <= '0;
      else if (clr_i)  dly_q[k] <= '0;
      else if (en_i)   dly_q[k] <= stg_in[k];
    end
  end

  assign res_o = stg_out[MAX_ORDER-1];

  // Top stage is never active below full order: its delay must not enter the result.
  p_bypass_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_i < ORD_W'(MAX_ORDER) |-> res_o == stg_in[MAX_ORDER-1]);
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  input  logic             cfg_load_i,
  input  logic [2:0]       cfg_order_i,
  input  logic [16:0]      cfg_dec_i,
  input  logic [6:0]       cfg_shift_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o,
  output logic             cfg_err_o
);
  localparam int ACC_W = IN_W + MAX_ORDER * (DEC_W - 1);

  cic_cfg_t                cfg;
  logic                    apply, take, hit_q, out_vld_q;
  logic [DEC_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] tap, res, scaled;
  logic [OUT_W-1:0]        out_q;

  cic_cfg_reg #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load_i),
    .order_i (cfg_order_i),
    .dec_i   (cfg_dec_i),
    .shift_i (cfg_shift_i),
    .cfg_o   (cfg),
    .apply_o (apply),
    .err_o   (cfg_err_o)
  );

  assign take = in_valid_i && !apply;

  cic_integ_chain #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (apply),
    .en_i    (take),
    .data_i  (in_data_i),
    .order_i (cfg.order),
    .tap_o   (tap)
  );

  // Rate change: count accepted samples, flag the R-th.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (apply) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (take) begin
      hit_q <= (cnt_q == cfg.dec - DEC_W'(1));
      cnt_q <= (cnt_q == cfg.dec - DEC_W'(1)) ? '0 : cnt_q + DEC_W'(1);
    end else begin
      hit_q <= 1'b0;
    end
  end

  cic_comb_chain #(.ACC_W(ACC_W)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (apply),
    .en_i    (hit_q),
    .order_i (cfg.order),
    .data_i  (tap),
    .res_o   (res)
  );

  assign scaled = res >>> cfg.shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else begin
      out_vld_q <= hit_q && !apply;
      if (hit_q) out_q <= scaled[OUT_W-1:0];
    end
  end

  assign out_valid_o = out_vld_q;
  assign out_data_o  = out_q;

  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < cfg.dec);
  p_valid_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 2));
  p_no_count_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i && !cfg_load_i |=> $stable(cnt_q));
endmodule

// File: tb/cic_decim_tb.sv
module cic_decim_tb;
  localparam int IN_W = 16, OUT_W = 16, ACC_W = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, cfg_load = 1'b0;
  logic [15:0] in_data = '0;
  logic [2:0]  cfg_order = '0;
  logic [16:0] cfg_dec = '0;
  logic [6:0]  cfg_shift = '0;
  logic        out_valid, cfg_err;
  logic [15:0] out_data;

  always #5 clk = ~clk;

  cic_decim #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .cfg_load_i(cfg_load), .cfg_order_i(cfg_order), .cfg_dec_i(cfg_dec),
    .cfg_shift_i(cfg_shift), .out_valid_o(out_valid), .out_data_o(out_data),
    .cfg_err_o(cfg_err)
  );

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";
  logic [15:0] exp_q[$];

  // Reference model state
  int m_ord = 5, m_dec = 4, m_sh = 10, m_cnt = 0;
  logic signed [ACC_W-1:0] m_acc[5], m_dly[5];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 5; k++) begin m_acc[k] = '0; m_dly[k] = '0; end
    m_cnt = 0;
  endtask

  task automatic model_step(input logic [15:0] x);
    logic signed [ACC_W-1:0] v, t;
    m_acc[0] = m_acc[0] + ACC_W'($signed(x));
    for (int k = 1; k < 5; k++) m_acc[k] = m_acc[k] + m_acc[k-1];
    m_cnt++;
    if (m_cnt == m_dec) begin
      m_cnt = 0;
      v = m_acc[m_ord-1];
      for (int k = 0; k < m_ord; k++) begin t = v - m_dly[k]; m_dly[k] = v; v = t; end
      v = v >>> m_sh;
      exp_q.push_back(v[15:0]);
    end
  endtask

  function automatic bit cfg_ok(input int o, input int d, input int s);
    int mx;
    mx = (o == 5) ? 512 : (o == 4) ? 2048 : (o == 3) ? 32768 : 65536;
    return o >= 1 && o <= 5 && d >= 4 && d <= mx && s <= ACC_W - OUT_W;
  endfunction

  task automatic load(input int o, input int d, input int s, input string req);
    bit ok;
    ok = cfg_ok(o, d, s);
    @(negedge clk);
    in_valid = 1'b0; cfg_load = 1'b1;
    cfg_order = 3'(o); cfg_dec = 17'(d); cfg_shift = 7'(s);
    if (ok) begin m_ord = o; m_dec = d; m_sh = s; model_clear(); end
    @(negedge clk);
    cfg_load = 1'b0;
    chk(cfg_err == !ok, req, cfg_err, !ok);
  endtask

  task automatic send(input logic [15:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    model_step(x);
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int n, input int gaps, input int amp);
    for (int i = 0; i < n; i++) begin
      send(16'($urandom_range(2 * amp) - amp));
      if (gaps != 0 && ($urandom_range(3) == 0)) idle(1);
    end
    idle(4);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected strobe"}, out_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, cur_req, out_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(1'b0, "watchdog", cycles, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(cfg_err == 1'b0, "R1 err", cfg_err, 0);

    // R1: default order 5, dec 4, shift 10
    cur_req = "R1";
    burst(24, 0, 300);
    drained("R1 drain");

    // R3 wraparound in output slice, R10 latency
    load(1, 4, 0, "R3 load");
    cur_req = "R3";
    for (int i = 0; i < 3; i++) send(16'h7fff);
    send(16'h7fff);
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R10 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 strobe", out_valid, 1);
    chk(out_data == 16'hfffc, "R3 wrap", out_data, 16'hfffc);
    idle(3);
    drained("R3 drain");

    // R2 orders with gaps (R4: idle cycles ignored)
    load(2, 4, 4, "R2 load2");
    cur_req = "R2 order2";
    burst(40, 1, 1000);
    drained("R4 order2");
    load(3, 8, 9, "R2 load3");
    cur_req = "R2 order3";
    burst(64, 1, 1000);
    drained("R4 order3");
    load(4, 16, 16, "R2 load4");
    cur_req = "R2 order4";
    burst(96, 1, 1000);
    drained("R4 order4");

    // R6 order 5 at its max factor
    load(5, 512, 45, "R6 load 5/512");
    cur_req = "R6 order5 max";
    burst(1536, 0, 2000);
    drained("R6 order5 drain");

    // R9 rejected loads hold state mid-stream
    load(2, 4, 4, "R9 load base");
    cur_req = "R9";
    send(16'd100); send(16'd200); idle(1);
    load(0, 4, 4, "R7 order0");
    load(6, 8, 4, "R7 order6");
    load(3, 3, 4, "R5 dec3");
    load(5, 513, 4, "R6 5/513");
    load(4, 2049, 4, "R6 4/2049");
    load(3, 32769, 4, "R6 3/32769");
    load(2, 4, 81, "R8 shift81");
    send(16'd300); send(16'd400);
    burst(12, 1, 500);
    drained("R9 hold");

    // R9 accepted load clears partial count
    send(16'd50); send(16'd60); idle(1);
    load(1, 4, 2, "R9 clear");
    cur_req = "R9 clear";
    burst(8, 0, 800);
    drained("R9 clear drain");

    // Boundaries that must be accepted
    load(4, 2048, 20, "R6 4/2048");
    load(3, 32768, 45, "R6 3/32768");
    load(2, 65536, 32, "R6 2/65536");
    load(1, 4, 80, "R8 shift80");
    load(5, 4, 10, "R5 5/4");

    // R6 order 1 at 65536: DC 1000 scaled by 16 returns 1000
    load(1, 65536, 16, "R6 1/65536");
    cur_req = "R6 order1 max";
    for (int i = 0; i < 65536; i++) send(16'd1000);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_data == 16'd1000, "R6 dc", out_data, 1000);
    idle(3);
    drained("R4 order1 drain");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule